// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block controls a bank of 32 general-purpose pins through a small register file of 32-bit words. Software writes an output level, a drive enable and an open-drain flag for each pin. It also writes two 2-bit source selectors for each pin: one for the output level and one for the drive enable. A selector of zero keeps the pin under register control. The other three values hand the pin's level or enable to one of three alternate-function groups. Each group supplies a per-pin level vector and a per-pin enable vector.

The block drives a level and an output enable for every pad. In open-drain mode the pad can only be pulled low. The pad inputs pass through a two-flop synchroniser and can be read back as a word, whatever each pin's direction. Three routing words and six input-select words are only stored and read back. A 64-pin system uses two independent instances.

Registers use MSB-first pin numbering: pin n sits at bit 31−n of every one-bit-per-pin register. The pad vectors at the ports use natural numbering, so bit n is pin n.

Top module: `pinbank_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every writable register. After reset every pad has `pad_oe` = 0 and `pad_out` = 0, `rsp_valid` is 0, and every mapped word reads 0 while `pad_in` is 0.
- R2: A read request (`req_valid`=1, `req_write`=0) sampled at a clock edge gives `rsp_valid`=1 and the read data after that edge, for exactly one cycle. A write request never raises `rsp_valid`.
- R3: The following byte offsets read back the last value written to them: 0x00 level, 0x04 drive enable, 0x08 and 0x0C output-source low and high, 0x10 and 0x14 enable-source low and high, 0x18 open-drain, 0x20–0x28 routing words, 0x30–0x44 input-select words.
- R4: Pin n uses bit 31−n of the level (0x00), drive-enable (0x04), open-drain (0x18) and input (0x1C) words. At the ports, pin n is bit n of `pad_out`, `pad_oe`, `pad_in` and the alternate vectors.
- R5: Pins 0–15 take their 2-bit selectors from the low words (0x08 for output, 0x10 for enable) at bits [(15−n)·2+1 : (15−n)·2]. Pins 16–31 take theirs from the high words (0x0C, 0x14) at bits [(31−n)·2+1 : (31−n)·2].
- R6: With selector 00, the pin's level is its bit in 0x00 and its enable is its bit in 0x04. An enable of 1 drives the pin and 0 floats it.
- R7: Selector values 01, 10 and 11 take the level (output selector) or the enable (enable selector) from `alt1_*`, `alt2_*` and `alt3_*`. The two selectors of a pin act independently.
- R8: With a pin's open-drain bit set, `pad_out` is 0, and `pad_oe` is 1 only when the selected enable is 1 and the selected level is 0. With the bit clear, the pin drives push-pull.
- R9: Offset 0x1C returns the pad levels after two synchroniser flops. A `pad_in` change that precedes a read by one or two clock edges is not yet visible. After two edges it is visible.
- R10: Writes to 0x1C, to the reserved word 0x2C, to offsets above 0x44 and to addresses not aligned to a word are dropped. Those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| alt1_out | input | 32 | Alternate group 1 level, bit n = pin n |
| alt1_oe | input | 32 | Alternate group 1 enable |
| alt2_out | input | 32 | Alternate group 2 level |
| alt2_oe | input | 32 | Alternate group 2 enable |
| alt3_out | input | 32 | Alternate group 3 level |
| alt3_oe | input | 32 | Alternate group 3 enable |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad output enable |

## Verification
The assertions assume that `rst` is held high at the first clock edge. They also assume that requests change only away from the active edge, so each request is sampled exactly once. The bench drives every input on the falling edge and asserts reset from time zero. It holds `pad_in` steady for the whole of each read sequence, except in the test that measures the synchroniser delay. The alternate vectors are fixed patterns that differ from one another, so a wrong source choice shows at the pads.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int unsigned REG_W       = 32;
    localparam int unsigned ALT_GROUPS  = 3;
    localparam int unsigned ROUTE_WORDS = 3;
    localparam int unsigned ISEL_WORDS  = 6;

    // word indices (byte offset / 4); order fixed by software view
    localparam int W_DOUT    = 0;
    localparam int W_DRIVE   = 1;
    localparam int W_OSEL_LO = 2;
    localparam int W_OSEL_HI = 3;
    localparam int W_TSEL_LO = 4;
    localparam int W_TSEL_HI = 5;
    localparam int W_ODRAIN  = 6;
    localparam int W_INPUT   = 7;
    localparam int W_ROUTE0  = 8;
    localparam int W_RSVD    = 11;
    localparam int W_ISEL0   = 12;

    typedef enum logic [1:0] {
        SRC_GPIO = 2'b00,
        SRC_ALT1 = 2'b01,
        SRC_ALT2 = 2'b10,
        SRC_ALT3 = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] dout;
        logic [REG_W-1:0] drive;
        logic [REG_W-1:0] osel_lo;
        logic [REG_W-1:0] osel_hi;
        logic [REG_W-1:0] tsel_lo;
        logic [REG_W-1:0] tsel_hi;
        logic [REG_W-1:0] odrain;
    } pin_cfg_t;

    typedef struct packed {
        logic val;
        logic en;
    } pin_drive_t;

    // choose register bit or one of the alternate group bits
    function automatic logic pick_src(src_sel_e sel, logic gpio_bit,
                                      logic [ALT_GROUPS-1:0] alt_bits);
        logic r;
        unique case (sel)
            SRC_GPIO: r = gpio_bit;
            SRC_ALT1: r = alt_bits[0];
            SRC_ALT2: r = alt_bits[1];
            SRC_ALT3: r = alt_bits[2];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [REG_W-1:0] req_wdata,
    input  logic [REG_W-1:0] in_word,
    output pin_cfg_t         cfg,
    output logic             rsp_valid,
    output logic [REG_W-1:0] rsp_rdata
);
    localparam int WIW = AW - 2;

    logic [WIW-1:0]   widx;
    logic             aligned;
    int               wsel;
    logic             wr_en;
    logic             rd_en;
    pin_cfg_t         cfg_q;
    logic [REG_W-1:0] route_q [ROUTE_WORDS];
    logic [REG_W-1:0] isel_q  [ISEL_WORDS];
    logic [REG_W-1:0] rdata_d;

    assign widx    = req_addr[AW-1:2];
    assign aligned = (req_addr[1:0] == 2'b00);
    assign wsel    = aligned ? int'(widx) : -1;
    assign wr_en   = req_valid &  req_write;
    assign rd_en   = req_valid & ~req_write;

    // pin configuration words
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (wsel)
                W_DOUT:    cfg_q.dout    <= req_wdata;
                W_DRIVE:   cfg_q.drive   <= req_wdata;
                W_OSEL_LO: cfg_q.osel_lo <= req_wdata;
                W_OSEL_HI: cfg_q.osel_hi <= req_wdata;
                W_TSEL_LO: cfg_q.tsel_lo <= req_wdata;
                W_TSEL_HI: cfg_q.tsel_hi <= req_wdata;
                W_ODRAIN:  cfg_q.odrain  <= req_wdata;
                default:   ;
            endcase
        end
    end

    // storage-only words
    genvar k;
    generate
        for (k = 0; k < ROUTE_WORDS; k++) begin : g_route
            always_ff @(posedge clk) begin
                if (rst)                               route_q[k] <= '0;
                else if (wr_en && wsel == W_ROUTE0 + k) route_q[k] <= req_wdata;
            end
        end
        for (k = 0; k < ISEL_WORDS; k++) begin : g_isel
            always_ff @(posedge clk) begin
                if (rst)                              isel_q[k] <= '0;
                else if (wr_en && wsel == W_ISEL0 + k) isel_q[k] <= req_wdata;
            end
        end
    endgenerate

    // read mux
    always_comb begin
        rdata_d = '0;
        case (wsel)
            W_DOUT:    rdata_d = cfg_q.dout;
            W_DRIVE:   rdata_d = cfg_q.drive;
            W_OSEL_LO: rdata_d = cfg_q.osel_lo;
            W_OSEL_HI: rdata_d = cfg_q.osel_hi;
            W_TSEL_LO: rdata_d = cfg_q.tsel_lo;
            W_TSEL_HI: rdata_d = cfg_q.tsel_hi;
            W_ODRAIN:  rdata_d = cfg_q.odrain;
            W_INPUT:   rdata_d = in_word;
            W_RSVD:    rdata_d = '0;
            default: begin
                for (int r = 0; r < ROUTE_WORDS; r++)
                    if (wsel == W_ROUTE0 + r) rdata_d = route_q[r];
                for (int i = 0; i < ISEL_WORDS; i++)
                    if (wsel == W_ISEL0 + i) rdata_d = isel_q[i];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) rsp_rdata <= rdata_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/pinbank_pinmux.sv
module pinbank_pinmux
    import pinbank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  pin_cfg_t                        cfg,
    input  logic [ALT_GROUPS-1:0][NPINS-1:0] alt_val,
    input  logic [ALT_GROUPS-1:0][NPINS-1:0] alt_en,
    output logic [NPINS-1:0]                pad_out,
    output logic [NPINS-1:0]                pad_oe,
    output logic [NPINS-1:0]                od_mask
);
    localparam int HALF = NPINS / 2;

    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_pin
            localparam int RB = REG_W - 1 - g;   // MSB-first register bit
            logic [1:0] osel;
            logic [1:0] tsel;
            logic [ALT_GROUPS-1:0] a_val;
            logic [ALT_GROUPS-1:0] a_en;
            pin_drive_t drv;
            logic od;

            if (g < HALF) begin : g_lo
                localparam int FO = (HALF - 1 - g) * 2;
                assign osel = cfg.osel_lo[FO +: 2];
                assign tsel = cfg.tsel_lo[FO +: 2];
            end else begin : g_hi
                localparam int FO = (NPINS - 1 - g) * 2;
                assign osel = cfg.osel_hi[FO +: 2];
                assign tsel = cfg.tsel_hi[FO +: 2];
            end

            for (genvar a = 0; a < ALT_GROUPS; a++) begin : g_alt
                assign a_val[a] = alt_val[a][g];
                assign a_en[a]  = alt_en[a][g];
            end

            always_comb begin
                drv.val = pick_src(src_sel_e'(osel), cfg.dout[RB],  a_val);
                drv.en  = pick_src(src_sel_e'(tsel), cfg.drive[RB], a_en);
            end

            assign od         = cfg.odrain[RB];
            assign od_mask[g] = od;
            assign pad_out[g] = od ? 1'b0 : drv.val;
            assign pad_oe[g]  = od ? (drv.en & ~drv.val) : drv.en;
        end
    endgenerate
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int AW          = 8,
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [REG_W-1:0] req_wdata,
    output logic             rsp_valid,
    output logic [REG_W-1:0] rsp_rdata,
    input  logic [NPINS-1:0] alt1_out,
    input  logic [NPINS-1:0] alt1_oe,
    input  logic [NPINS-1:0] alt2_out,
    input  logic [NPINS-1:0] alt2_oe,
    input  logic [NPINS-1:0] alt3_out,
    input  logic [NPINS-1:0] alt3_oe,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    pin_cfg_t                         cfg;
    logic [NPINS-1:0]                 pad_sync;
    logic [REG_W-1:0]                 in_word;
    logic [NPINS-1:0]                 od_mask;
    logic [ALT_GROUPS-1:0][NPINS-1:0] alt_val;
    logic [ALT_GROUPS-1:0][NPINS-1:0] alt_en;

    assign alt_val = {alt3_out, alt2_out, alt1_out};
    assign alt_en  = {alt3_oe,  alt2_oe,  alt1_oe};

    pinbank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    // pin n appears at register bit REG_W-1-n
    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_inmap
            assign in_word[REG_W-1-g] = pad_sync[g];
        end
        if (NPINS < REG_W) begin : g_inpad
            assign in_word[REG_W-NPINS-1:0] = '0;
        end
    endgenerate

    pinbank_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .in_word   (in_word),
        .cfg       (cfg),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    pinbank_pinmux #(.NPINS(NPINS)) u_mux (
        .cfg     (cfg),
        .alt_val (alt_val),
        .alt_en  (alt_en),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .od_mask (od_mask)
    );
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
    parameter int AW    = 8,
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic [AW-1:0]    req_addr,
    input logic [31:0]      req_wdata,
    input logic             rsp_valid,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] od_mask,
    input logic [31:0]      dout_q
);
    AST_RD_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid); // R2

    AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write)); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && pad_out == '0 && !rsp_valid)); // R1

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
        (pad_out & od_mask) == '0); // R8

    AST_DOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == '0) |=> dout_q == $past(req_wdata)); // R3
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.AW(AW), .NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .od_mask   (od_mask),
    .dout_q    (cfg.dout)
);

// File: tb/pinbank_ctrl_test.sv
module pinbank_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] alt1_out = 32'h3C5A_96E1, alt1_oe = 32'hF0F0_1234;
    logic [31:0] alt2_out = 32'hA5C3_0FF0, alt2_oe = 32'h0F1E_2D3C;
    logic [31:0] alt3_out = 32'h6996_C33C, alt3_oe = 32'hFF00_AA55;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] m [0:17];   // bench view of register words

    always #5 clk = ~clk;

    pinbank_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .alt1_out(alt1_out), .alt1_oe(alt1_oe),
        .alt2_out(alt2_out), .alt2_oe(alt2_oe), .alt3_out(alt3_out),
        .alt3_oe(alt3_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bitrev(logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    // expected pad vectors from the register view and alternate inputs
    task automatic model(output logic [31:0] eo, output logic [31:0] ee);
        for (int n = 0; n < 32; n++) begin
            int rb = 31 - n;
            int sh = (n < 16) ? (15 - n) * 2 : (31 - n) * 2;
            logic [1:0] os = (n < 16) ? m[2][sh +: 2] : m[3][sh +: 2];
            logic [1:0] ts = (n < 16) ? m[4][sh +: 2] : m[5][sh +: 2];
            logic v, e, od;
            case (os)
                2'd0: v = m[0][rb];
                2'd1: v = alt1_out[n];
                2'd2: v = alt2_out[n];
                default: v = alt3_out[n];
            endcase
            case (ts)
                2'd0: e = m[1][rb];
                2'd1: e = alt1_oe[n];
                2'd2: e = alt2_oe[n];
                default: e = alt3_oe[n];
            endcase
            od = m[6][rb];
            eo[n] = od ? 1'b0 : v;
            ee[n] = od ? (e & ~v) : e;
        end
    endtask

    task automatic check_pads(string req);
        logic [31:0] eo, ee;
        model(eo, ee);
        chk(req, pad_out, eo);
        chk(req, pad_oe, ee);
    endtask

    // all bus tasks start and end at a falling edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        if (a[1:0] == 2'b00 && a <= 8'h44 && a != 8'h1C && a != 8'h2C)
            m[a >> 2] = d;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d, output logic v);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata; v = rsp_valid;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        logic [31:0] d; logic v;
        rd(a, d, v);
        chk({req, " rsp_valid"}, {31'b0, v}, 32'd1);
        chk(req, d, exp);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] d; logic v;
        for (int i = 0; i < 18; i++) m[i] = '0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_out", pad_out, '0);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, '0);
        for (int w = 0; w < 18; w++) rd_chk("R1 word", 8'(w * 4), '0);

        // R2: no response for a write; response lasts one cycle
        wr(8'h00, 32'h1234_5678);
        chk("R2 write no rsp", {31'b0, rsp_valid}, '0);
        rd_chk("R2 read", 8'h00, 32'h1234_5678);
        @(negedge clk);
        chk("R2 one cycle", {31'b0, rsp_valid}, '0);

        // R3: readback of every writable word
        for (int w = 0; w < 18; w++) begin
            if (w != 7 && w != 11) wr(8'(w * 4), 32'hC0DE_0000 ^ (32'(w) * 32'h0101_0301));
        end
        for (int w = 0; w < 18; w++) begin
            if (w != 7 && w != 11) rd_chk("R3 readback", 8'(w * 4), m[w]);
        end

        // R10: dropped writes, zero reads
        wr(8'h1C, 32'hFFFF_FFFF);
        rd_chk("R10 input ro", 8'h1C, 32'h0);
        wr(8'h2C, 32'hDEAD_BEEF);
        rd_chk("R10 reserved", 8'h2C, 32'h0);
        wr(8'h48, 32'hDEAD_BEEF);
        rd_chk("R10 above map", 8'h48, 32'h0);
        wr(8'h01, 32'h0BAD_0BAD);
        rd_chk("R10 unaligned rd", 8'h01, 32'h0);
        rd_chk("R10 unaligned wr", 8'h00, m[0]);

        // clear selects and open-drain
        for (int w = 2; w <= 6; w++) wr(8'(w * 4), 32'h0);

        // R4/R6: walking pin in GPIO mode
        for (int n = 0; n < 32; n++) begin
            wr(8'h00, 32'h1 << (31 - n));
            wr(8'h04, 32'h1 << (31 - n));
            chk("R4 pad_out pin", pad_out, 32'h1 << n);
            chk("R6 pad_oe pin", pad_oe, 32'h1 << n);
        end
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0);
        chk("R6 floated", pad_oe, 32'h0);
        chk("R6 level", pad_out, 32'hFFFF_FFFF);

        // R5/R7: per-pin selector sweep
        wr(8'h00, 32'h9A3C_5E71);
        wr(8'h04, 32'h6B2D_F08C);
        for (int n = 0; n < 32; n++) begin
            for (int s = 0; s < 4; s++) begin
                int sh = (n < 16) ? (15 - n) * 2 : (31 - n) * 2;
                logic [31:0] f = 32'(s) << sh;
                logic [31:0] t = 32'(3 - s) << sh;
                wr(8'h08, (n < 16) ? f : 32'h0);
                wr(8'h0C, (n < 16) ? 32'h0 : f);
                wr(8'h10, (n < 16) ? t : 32'h0);
                wr(8'h14, (n < 16) ? 32'h0 : t);
                check_pads("R5 R7 select sweep");
            end
        end

        // R7: whole port on each alternate group
        for (int s = 1; s < 4; s++) begin
            logic [31:0] all = 32'h5555_5555 * 32'(s);
            wr(8'h08, all); wr(8'h0C, all); wr(8'h10, all); wr(8'h14, all);
            check_pads("R7 all alt");
        end
        for (int w = 2; w <= 5; w++) wr(8'(w * 4), 32'h0);

        // R8: open-drain per pin, then all pins, then with alternates
        for (int n = 0; n < 32; n++) begin
            wr(8'h18, 32'h1 << (31 - n));
            check_pads("R8 od pin");
        end
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        chk("R8 od out low", pad_out, 32'h0);
        chk("R8 od oe", pad_oe, ~bitrev(m[0]));
        wr(8'h08, 32'hAAAA_AAAA); wr(8'h0C, 32'hAAAA_AAAA);
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
        check_pads("R8 od alt");
        wr(8'h18, 32'h0);
        check_pads("R8 push-pull");

        // R9: two-flop input path
        pad_in = 32'h8000_0003;
        rd_chk("R9 sync edge1", 8'h1C, 32'h0);
        rd_chk("R9 sync edge2", 8'h1C, 32'h0);
        rd_chk("R9 sync edge3", 8'h1C, bitrev(32'h8000_0003));
        for (int k = 0; k < 8; k++) begin
            logic [31:0] p = 32'h1 << (k * 4) | 32'h0F00_0000 >> k;
            pad_in = p;
            @(negedge clk); @(negedge clk);
            rd_chk("R4 R9 input map", 8'h1C, bitrev(p));
        end
        wr(8'h1C, 32'h0);
        rd_chk("R10 input ro", 8'h1C, bitrev(pad_in));

        // R1: reset in the middle of operation
        rst = 1'b1; pad_in = '0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 18; i++) m[i] = '0;
        chk("R1 mid pad_oe", pad_oe, '0);
        chk("R1 mid pad_out", pad_out, '0);
        rd(8'h04, d, v);
        chk("R1 mid drive word", d, '0);
        rd_chk("R1 mid route", 8'h20, '0);

        summary();
    end
endmodule